// File: doc/BRIEF.md
# Reciprocal Square Root Estimator

This block returns a coarse estimate of 1/sqrt(x) in one clock cycle. It accepts a single-precision floating-point operand, or a 32-bit unsigned fixed-point fraction when the fixed-point mode is selected. A compiler or microcode sequence uses the estimate as the seed for its own refinement iterations. No iteration is performed inside the block.

Both modes share one lookup table with 256 eight-bit entries. The table has two halves. One half serves operands scaled into [0.25, 0.5) and the other serves operands scaled into [0.5, 1.0). The half is chosen by the parity of the operand's exponent in float mode, and by the top operand bit in fixed mode. Each entry is computed at elaboration by a constant function that runs an integer square-root search. Special operands bypass the table and produce fixed results and exception flags.

Top module: `rsqrt_est`

## Requirements
- R1: A float NaN operand (exponent field all ones, fraction nonzero) yields 0x7FC00000. flag_invalid is set exactly when the operand is signaling, which means fraction bit 22 is 0.
- R2: A float zero of either sign yields infinity with the operand's sign (0x7F800000 or 0xFF800000) and sets flag_divzero. A subnormal operand counts as zero when ftz is 1.
- R3: A negative float operand that is neither zero nor NaN, including negative infinity, yields 0x7FC00000 and sets flag_invalid.
- R4: Positive infinity yields 0x00000000 with no flag set.
- R5: For a positive normal operand with biased exponent E, the result is built as follows. The sign is 0 and the exponent field is floor((380 − E)/2). The fraction field is the 8-bit estimate in bits 22:15 with zeros below it. To form the estimate, scale the operand to a in [0.25,0.5) when E is odd, or to a in [0.5,1) when E is even. Take q = floor(512a) and D = 512 in the first case, or q = floor(256a) and D = 256 in the second. The estimate is the low 8 bits of round(256/sqrt((q+0.5)/D)). No flag is set.
- R6: With ftz at 0, a positive subnormal operand is first normalised to 1.f × 2^(e−127), with e = −(leading zeros of the 23-bit fraction). It then follows R5, using e in place of E for both the parity and the exponent formula.
- R7: In fixed-point mode (fixed_mode = 1), an operand whose bits 31:30 are both 0 yields 0xFFFFFFFF. Any other operand is read as a = operand/2^32 and gives {1'b1, estimate, 23'b0}, with the estimate formed as in R5. No flag is ever set in this mode.
- R8: out_valid rises exactly one cycle after in_valid. The result and flags are loaded only on an accepted operand and hold otherwise. Reset clears out_valid, result and both flags to 0.
- R9: flag_invalid and flag_divzero are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| fixed_mode | input | 1 | 1 = unsigned fixed-point estimate, 0 = float |
| ftz | input | 1 | Treat float subnormals as zero |
| op_in | input | 32 | Operand |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 32 | Estimate or special value |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_divzero | output | 1 | Divide-by-zero flag |

## Verification
The sign bit can meet another classification in the same operand, so two special-case rules apply to one input at once. A negative zero is both zero and negative. A negative signaling NaN is both NaN and negative. A negative subnormal with ftz set is both flushed and negative. The bench drives each of these operands. It expects the NaN rule to win over the sign rule, and the zero rule to win over the sign rule: a negative zero gives -infinity with only divide-by-zero set, and a negative NaN gives the canonical NaN with invalid set only when the NaN is signaling. In every one of these cases it also checks that the two flags never appear together.

// File: rtl/rsqrt_est.sv
module rsqrt_est #(
  parameter int IDX_BITS = 7,
  parameter int EST_BITS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        fixed_mode,
  input  logic        ftz,
  input  logic [31:0] op_in,
  output logic        out_valid,
  output logic [31:0] result,
  output logic        flag_invalid,
  output logic        flag_divzero
);
  localparam int          ENTRIES = 2 ** (IDX_BITS + 1);
  localparam int          HALF    = 2 ** IDX_BITS;
  localparam int          FPAD    = 23 - EST_BITS;
  localparam int          XPAD    = 31 - EST_BITS;
  localparam logic [31:0] QNAN    = 32'h7FC0_0000;

  // Largest s with (2s-1)^2 (2q+1) <= 2^(2E+3) D, i.e. s = round(2^E / sqrt((q+0.5)/D))
  function automatic logic [EST_BITS-1:0] seg_est(input int idx, input logic odd);
    longint q, lim, s, t;
    q   = longint'(HALF) + longint'(idx);
    lim = longint'(1) << (2 * EST_BITS + 3 + IDX_BITS + (odd ? 2 : 1));
    s   = 0;
    for (int b = EST_BITS + 1; b >= 0; b--) begin
      t = s | (longint'(1) << b);
      if ((2 * t - 1) * (2 * t - 1) * (2 * q + 1) <= lim) s = t;
    end
    return s[EST_BITS-1:0];
  endfunction

  logic [EST_BITS-1:0] lut [ENTRIES];
  for (genvar g = 0; g < ENTRIES; g++) begin : g_lut
    assign lut[g] = seg_est(g % HALF, 1'(g >= HALF));
  end

  wire        sgn      = op_in[31];
  wire [7:0]  bexp     = op_in[30:23];
  wire [22:0] man      = op_in[22:0];
  wire        exp_max  = &bexp;
  wire        exp_zero = ~|bexp;
  wire        man_zero = ~|man;
  wire        is_nan   = exp_max & ~man_zero;
  wire        is_inf   = exp_max & man_zero;
  wire        is_zero  = exp_zero & (man_zero | ftz);

  logic [4:0] lz;
  always_comb begin
    lz = 5'd0;
    for (int i = 0; i < 23; i++)
      if (man[i]) lz = 5'(22 - i);
  end

  wire [22:0]       nfrac   = exp_zero ? 23'(man << (lz + 5'd1)) : man;
  wire signed [9:0] eff_exp = exp_zero ? -$signed({5'd0, lz}) : $signed({2'd0, bexp});
  wire signed [9:0] num     = 10'sd380 - eff_exp;
  wire [7:0]        res_exp = num[8:1];

  wire [IDX_BITS:0] f_idx = {eff_exp[0], nfrac[22 -: IDX_BITS]};
  wire [IDX_BITS:0] x_idx = op_in[31] ? {1'b0, op_in[30 -: IDX_BITS]}
                                      : {1'b1, op_in[29 -: IDX_BITS]};
  wire [EST_BITS-1:0] est = lut[fixed_mode ? x_idx : f_idx];

  logic [31:0] f_res;
  logic        f_inv, f_dz;
  always_comb begin
    f_res = {1'b0, res_exp, est, {FPAD{1'b0}}};
    f_inv = 1'b0;
    f_dz  = 1'b0;
    if (is_nan) begin
      f_res = QNAN;
      f_inv = ~man[22];
    end else if (is_zero) begin
      f_res = {sgn, 8'hFF, 23'd0};
      f_dz  = 1'b1;
    end else if (sgn) begin
      f_res = QNAN;
      f_inv = 1'b1;
    end else if (is_inf) begin
      f_res = 32'd0;
    end
  end

  wire [31:0] x_res = (op_in[31:30] == 2'b00) ? 32'hFFFF_FFFF : {1'b1, est, {XPAD{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      result       <= 32'd0;
      flag_invalid <= 1'b0;
      flag_divzero <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result       <= fixed_mode ? x_res : f_res;
        flag_invalid <= ~fixed_mode & f_inv;
        flag_divzero <= ~fixed_mode & f_dz;
      end
    end
  end

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_invalid && flag_divzero));
  assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(flag_invalid));
  assert_fixed_noflag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && fixed_mode |=> !flag_invalid && !flag_divzero);
  assert_nan_canon_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !fixed_mode && (&op_in[30:23]) && (|op_in[22:0]) |=> result == QNAN);
  assert_pos_inf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !fixed_mode && op_in == 32'h7F80_0000 |=> result == 32'd0 && !flag_invalid);
  assert_zero_dz_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !fixed_mode && op_in[30:0] == 31'd0 |=> flag_divzero && result[30:23] == 8'hFF);
endmodule

// File: tb/test_rsqrt_est.sv
`timescale 1ns/1ps
module test_rsqrt_est;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        fixed_mode = 1'b0;
  logic        ftz = 1'b0;
  logic [31:0] op_in = 32'd0;
  logic        out_valid, flag_invalid, flag_divzero;
  logic [31:0] result;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  rsqrt_est i_rsqrt_est (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fixed_mode(fixed_mode),
    .ftz(ftz), .op_in(op_in), .out_valid(out_valid), .result(result),
    .flag_invalid(flag_invalid), .flag_divzero(flag_divzero));

  task automatic check(input string req, input logic [33:0] got, input logic [33:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] est_of(input int q, input int d);
    real r;
    r = 256.0 / $sqrt((real'(q) + 0.5) / real'(d));
    return 8'($rtoi(r + 0.5));
  endfunction

  function automatic logic [33:0] model(input logic fx, input logic fz, input logic [31:0] v);
    int e, q, d;
    logic [22:0] f;
    real a;
    if (fx) begin
      if (v[31:30] == 2'b00) return {2'b00, 32'hFFFF_FFFF};
      a = real'(v) / 4294967296.0;
      if (a < 0.5) begin q = $rtoi(a * 512.0); d = 512; end
      else         begin q = $rtoi(a * 256.0); d = 256; end
      return {2'b00, 1'b1, est_of(q, d), 23'd0};
    end
    if (v[30:23] == 8'hFF && v[22:0] != 0) return {~v[22], 1'b0, 32'h7FC0_0000};
    if (v[30:23] == 0 && (v[22:0] == 0 || fz)) return {2'b01, v[31], 8'hFF, 23'd0};
    if (v[31]) return {2'b10, 32'h7FC0_0000};
    if (v[30:23] == 8'hFF) return 34'd0;
    e = int'(v[30:23]);
    f = v[22:0];
    if (e == 0) begin
      e = 1;
      while (!f[22]) begin f = f << 1; e--; end
      f = f << 1; e--;
    end
    a = (1.0 + real'(f) / 8388608.0) / ((e % 2 != 0) ? 4.0 : 2.0);
    if (e % 2 != 0) begin q = $rtoi(a * 512.0); d = 512; end
    else            begin q = $rtoi(a * 256.0); d = 256; end
    return {2'b00, 1'b0, 8'((380 - e) / 2), est_of(q, d), 15'd0};
  endfunction

  task automatic run(input string req, input logic fx, input logic fz, input logic [31:0] v);
    @(negedge clk);
    in_valid = 1'b1; fixed_mode = fx; ftz = fz; op_in = v;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {flag_invalid, flag_divzero, result}, model(fx, fz, v));
    if (!out_valid) check({req, " R8 out_valid"}, 34'(out_valid), 34'd1);
  endtask

  task automatic t_reset();
    check("R8 reset", {out_valid, flag_invalid, flag_divzero, result[30:0]}, 34'd0);
  endtask

  task automatic t_known();
    run("R5 1.0", 0, 0, 32'h3F80_0000);
    check("R5 1.0 const", 34'(result), 34'h3F7F_8000);
    run("R5 4.0", 0, 0, 32'h4080_0000);
    check("R5 4.0 const", 34'(result), 34'h3EFF_8000);
    run("R5 2.0", 0, 0, 32'h4000_0000);
    check("R5 2.0 const", 34'(result), 34'h3F34_8000);
  endtask

  task automatic t_sweep();
    logic [31:0] s = 32'h1234_5679;
    for (int i = 0; i < 80; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      run("R5 sweep", 0, 0, {1'b0, 8'(1 + (i * 37) % 253), s[22:0]});
    end
    run("R5 max exp", 0, 0, 32'h7F7F_FFFF);
    run("R5 min normal", 0, 0, 32'h0080_0000);
  endtask

  task automatic t_denorm();
    run("R6 smallest", 0, 0, 32'h0000_0001);
    run("R6 half", 0, 0, 32'h0040_0000);
    run("R6 mixed", 0, 0, 32'h0012_3456);
    run("R6 top", 0, 0, 32'h007F_FFFF);
    run("R2 flushed", 0, 1, 32'h0012_3456);
    run("R3 neg subnormal", 0, 0, 32'h8000_0100);
  endtask

  task automatic t_special();
    run("R2 +0", 0, 0, 32'h0000_0000);
    run("R2 -0", 0, 0, 32'h8000_0000);
    run("R2 -flushed", 0, 1, 32'h8000_0003);
    check("R9 -flushed no invalid", 34'(flag_invalid), 34'd0);
    run("R1 qnan", 0, 0, 32'h7FC0_0001);
    run("R1 snan", 0, 0, 32'h7F80_0001);
    run("R1 neg snan", 0, 0, 32'hFF80_0001);
    check("R9 neg snan", 34'(flag_divzero), 34'd0);
    run("R1 neg qnan", 0, 0, 32'hFFC0_0000);
    run("R3 -inf", 0, 0, 32'hFF80_0000);
    run("R3 -1.0", 0, 0, 32'hBF80_0000);
    run("R4 +inf", 0, 0, 32'h7F80_0000);
  endtask

  task automatic t_fixed();
    logic [31:0] s = 32'hCAFE_F00D;
    run("R7 low", 1, 0, 32'h3FFF_FFFF);
    run("R7 zero", 1, 0, 32'h0000_0000);
    run("R7 quarter", 1, 0, 32'h4000_0000);
    check("R7 quarter const", 34'(result), 34'hFF80_0000);
    run("R7 half", 1, 0, 32'h8000_0000);
    run("R7 max", 1, 0, 32'hFFFF_FFFF);
    run("R7 nan pattern ignored", 1, 0, 32'h7FA0_0000);
    for (int i = 0; i < 40; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      run("R7 sweep", 1, i[0], s);
    end
  endtask

  task automatic t_stream();
    @(negedge clk);
    in_valid = 1'b1; fixed_mode = 1'b0; op_in = 32'h3F80_0000;
    @(negedge clk);
    check("R8 stream A", {1'b0, out_valid, result}, {2'b01, 32'h3F7F_8000});
    op_in = 32'h0000_0000;
    @(negedge clk);
    in_valid = 1'b0; op_in = 32'h4080_0000;
    check("R8 stream B", {flag_divzero, out_valid, result}, {2'b11, 32'h7F80_0000});
    @(negedge clk);
    check("R8 hold", {flag_divzero, out_valid, result}, {2'b10, 32'h7F80_0000});
    @(negedge clk);
    check("R8 hold 2", {flag_divzero, out_valid, result}, {2'b10, 32'h7F80_0000});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_known();
    t_sweep();
    t_denorm();
    t_special();
    t_fixed();
    t_stream();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule